// File: doc/BRIEF.md
# Dual PLL Time-Constant Sequencer

This block chooses the loop time constants for two tracking loops in a broadcast data receiver: the 57 kHz carrier loop, which takes a one-bit select, and the 1187.5 Hz bit-clock loop, which takes a two-bit select. The loop arithmetic itself lives elsewhere. This block only produces the selects that the loops consume.

A mode input picks who owns the selects. In hardware mode, a resynchronization pulse drops both loops to their fastest constant so that they acquire quickly. The block then counts data-bit clock strobes and moves the constants toward the slowest setting, one step per fixed number of strobes, which gives better noise immunity once lock is held. In software mode, the selects are copied from two register fields, and the sequencer is held at its starting point. When the block returns to hardware mode, the ramp therefore begins again from the fastest setting.

Top module: `pll_tc_sequencer`

## Requirements
- R1: After reset, carrier_sel_o is 0 and bit_sel_o is 00, which are the fastest constants for hardware mode.
- R2: While sw_mode_i is 1, carrier_sel_o equals sw_carrier_i one clock later. The value 0 selects the 2 ms lock constant and the value 1 selects the 10 ms lock constant.
- R3: While sw_mode_i is 1, bit_sel_o equals sw_bit_i one clock later. The encoding is 00 for 5 ms, 01 for 15 ms, 10 for 35 ms and 11 for 76 ms.
- R4: In hardware mode, a cycle with resync_i high gives carrier_sel_o = 0 and bit_sel_o = 00 on the next clock, and the strobe count restarts from zero.
- R5: In hardware mode, bit_sel_o advances by one (00, then 01, then 10, then 11) on the clock that registers every 64th bit_tick_i strobe since the last restart.
- R6: In hardware mode, carrier_sel_o is 1 exactly when bit_sel_o is 10 or 11.
- R7: Once bit_sel_o reaches 11 in hardware mode, it stays at 11, with carrier_sel_o at 1, however many strobes follow, until the next restart.
- R8: When sw_mode_i goes from 1 to 0, the outputs become 0 and 00 on the next clock, and a full 64 strobes are needed before bit_sel_o reaches 01.
- R9: A resync_i pulse or bit_tick_i strobes in software mode leave carrier_sel_o and bit_sel_o unchanged.
- R10: If resync_i and a bit_tick_i strobe arrive in the same cycle, the resync takes effect and that strobe is not counted.
- R11: Clock cycles without a bit_tick_i strobe do not change the hardware-mode outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle strobe per recovered data-bit clock |
| resync_i | input | 1 | One-cycle request to restart the time-constant ramp |
| sw_mode_i | input | 1 | 0 = hardware sequencing, 1 = software selection |
| sw_carrier_i | input | 1 | Carrier-loop constant field used in software mode |
| sw_bit_i | input | 2 | Bit-loop constant field used in software mode |
| carrier_sel_o | output | 1 | Carrier-loop time-constant select |
| bit_sel_o | output | 2 | Bit-loop time-constant select |

## Verification
The assertions assume that bit_tick_i and resync_i are synchronous to clk and sampled as single-cycle levels. They also assume that the software fields are stable around the clock edge at which they are captured. The stimulus raises and lowers every input at the falling clock edge. Each strobe lasts exactly one cycle and is separated by at least one idle cycle, and the fields change only on falling edges. This keeps each strobe count and each capture tied to a known rising edge.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
package tc_pkg;
    localparam int BIT_SEL_W = 2;

    typedef logic [BIT_SEL_W-1:0] stage_t;

    typedef struct packed {
        logic   carrier_sel;
        stage_t bit_sel;
    } loop_sel_t;

    // Map a ramp stage onto the pair of loop selects.
    function automatic loop_sel_t stage_to_sel(stage_t stg, stage_t slow_from);
        loop_sel_t s;
        s.bit_sel     = stg;
        s.carrier_sel = (stg >= slow_from);
        return s;
    endfunction
endpackage

// File: rtl/tc_tick_counter.sv
`timescale 1ns/1ps
module tc_tick_counter #(
    parameter int STEP_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic step_o
);
    generate
        if (STEP_TICKS > 1) begin : g_count
            localparam int CW = $clog2(STEP_TICKS);
            localparam logic [CW-1:0] LAST = CW'(STEP_TICKS - 1);

            typedef struct packed {
                logic [CW-1:0] cnt;
            } cnt_state_t;

            cnt_state_t st_d, st_q;
            logic       wrap;

            always_comb begin
                st_d = st_q;
                wrap = tick_i && (st_q.cnt == LAST);
                if (clear_i) begin
                    st_d.cnt = '0;
                end else if (tick_i) begin
                    st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
                end
            end

            assign step_o = wrap && !clear_i;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            // R4 / R10: a clear wins over any strobe in the same cycle
            a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
                clear_i |=> st_q.cnt == '0);
            // R11: no strobe, no movement
            a_r11_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!clear_i && !tick_i) |=> $stable(st_q.cnt));
        end else begin : g_direct
            assign step_o = tick_i && !clear_i;
        end
    endgenerate
endmodule

// File: rtl/tc_stage_ladder.sv
`timescale 1ns/1ps
module tc_stage_ladder
    import tc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear_i,
    input  logic   step_i,
    output stage_t stage_nxt_o
);
    localparam stage_t TOP = '1;

    typedef struct packed {
        stage_t stage;
    } ladder_state_t;

    ladder_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.stage = '0;
        end else if (step_i && (st_q.stage != TOP)) begin
            st_d.stage = st_q.stage + 1'b1;
        end
    end

    assign stage_nxt_o = st_d.stage;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: restart lands on the fastest stage
    a_r4_clear_to_fast: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> st_q.stage == '0);
    // R5: each step moves exactly one stage
    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && st_q.stage != TOP) |=> st_q.stage == $past(st_q.stage) + 1'b1);
    // R7: slowest stage is held
    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stage == TOP && !clear_i) |=> st_q.stage == TOP);
    // R11: stage moves only on a step
    a_r11_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clear_i) |=> $stable(st_q.stage));
endmodule

// File: rtl/tc_sel_reg.sv
`timescale 1ns/1ps
module tc_sel_reg
    import tc_pkg::*;
#(
    parameter int SLOW_FROM = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sw_mode_i,
    input  logic   sw_carrier_i,
    input  stage_t sw_bit_i,
    input  stage_t stage_nxt_i,
    output logic   carrier_o,
    output stage_t bit_o
);
    localparam stage_t SLOW_STG = stage_t'(SLOW_FROM);

    loop_sel_t sel_d, sel_q;

    always_comb begin
        if (sw_mode_i) begin
            sel_d.carrier_sel = sw_carrier_i;
            sel_d.bit_sel     = sw_bit_i;
        end else begin
            sel_d = stage_to_sel(stage_nxt_i, SLOW_STG);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= stage_to_sel('0, SLOW_STG);
        end else begin
            sel_q <= sel_d;
        end
    end

    assign carrier_o = sel_q.carrier_sel;
    assign bit_o     = sel_q.bit_sel;

    // R2: software carrier field reaches the output one clock later
    a_r2_sw_carrier: assert property (@(posedge clk) disable iff (!rst_n)
        sw_mode_i |=> carrier_o == $past(sw_carrier_i));
    // R3: software bit field reaches the output one clock later
    a_r3_sw_bit: assert property (@(posedge clk) disable iff (!rst_n)
        sw_mode_i |=> bit_o == $past(sw_bit_i));
    // R6: hardware carrier select tracks the bit stage
    a_r6_carrier_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_mode_i |=> carrier_o == (bit_o >= SLOW_STG));
endmodule

// File: rtl/pll_tc_sequencer.sv
`timescale 1ns/1ps
module pll_tc_sequencer
    import tc_pkg::*;
#(
    parameter int STEP_TICKS = 64,
    parameter int SLOW_FROM  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick_i,
    input  logic                 resync_i,
    input  logic                 sw_mode_i,
    input  logic                 sw_carrier_i,
    input  logic [BIT_SEL_W-1:0] sw_bit_i,
    output logic                 carrier_sel_o,
    output logic [BIT_SEL_W-1:0] bit_sel_o
);
    logic   restart;
    logic   step;
    stage_t stage_nxt;

    // Software mode holds the ramp at its start, so leaving it restarts the ramp.
    assign restart = resync_i || sw_mode_i;

    tc_tick_counter #(.STEP_TICKS(STEP_TICKS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (restart),
        .tick_i  (bit_tick_i),
        .step_o  (step)
    );

    tc_stage_ladder u_ladder (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (restart),
        .step_i      (step),
        .stage_nxt_o (stage_nxt)
    );

    tc_sel_reg #(.SLOW_FROM(SLOW_FROM)) u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_mode_i    (sw_mode_i),
        .sw_carrier_i (sw_carrier_i),
        .sw_bit_i     (sw_bit_i),
        .stage_nxt_i  (stage_nxt),
        .carrier_o    (carrier_sel_o),
        .bit_o        (bit_sel_o)
    );

    // R4: hardware resync gives fastest outputs on the next clock
    a_r4_resync_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (resync_i && !sw_mode_i) |=> (bit_sel_o == '0 && !carrier_sel_o));
endmodule

// File: tb/pll_tc_sequencer_tb.sv
`timescale 1ns/1ps
module pll_tc_sequencer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick_i = 1'b0;
    logic       resync_i = 1'b0;
    logic       sw_mode_i = 1'b0;
    logic       sw_carrier_i = 1'b0;
    logic [1:0] sw_bit_i = 2'b00;
    logic       carrier_sel_o;
    logic [1:0] bit_sel_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    pll_tc_sequencer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_tick_i    (bit_tick_i),
        .resync_i      (resync_i),
        .sw_mode_i     (sw_mode_i),
        .sw_carrier_i  (sw_carrier_i),
        .sw_bit_i      (sw_bit_i),
        .carrier_sel_o (carrier_sel_o),
        .bit_sel_o     (bit_sel_o)
    );

    // exp packs {carrier, bit[1:0]}
    task automatic check(string req, logic [2:0] exp);
        logic [2:0] act;
        act = {carrier_sel_o, bit_sel_o};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic give_ticks(int n);
        for (int i = 0; i < n; i++) begin
            bit_tick_i = 1'b1;
            @(negedge clk);
            bit_tick_i = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic pulse_resync();
        resync_i = 1'b1;
        @(negedge clk);
        resync_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset", 3'b0_00);
    endtask

    task automatic t_ramp();
        give_ticks(63);  check("R5 before first step", 3'b0_00);
        give_ticks(1);   check("R5 first step", 3'b0_01);
        check("R6 carrier fast at 01", 3'b0_01);
        give_ticks(63);  check("R5 before second step", 3'b0_01);
        give_ticks(1);   check("R6 carrier slow at 10", 3'b1_10);
        give_ticks(64);  check("R5 third step", 3'b1_11);
    endtask

    task automatic t_saturate();
        give_ticks(200); check("R7 hold slowest", 3'b1_11);
    endtask

    task automatic t_resync();
        pulse_resync();  check("R4 resync to fastest", 3'b0_00);
        give_ticks(64);  check("R4 ramp after resync", 3'b0_01);
    endtask

    task automatic t_partial();
        pulse_resync();
        give_ticks(40);
        pulse_resync();
        give_ticks(63);  check("R4 count restarted", 3'b0_00);
        give_ticks(1);   check("R4 step after restart", 3'b0_01);
    endtask

    task automatic t_coincide();
        pulse_resync();
        give_ticks(63);
        bit_tick_i = 1'b1;
        resync_i   = 1'b1;
        @(negedge clk);
        bit_tick_i = 1'b0;
        resync_i   = 1'b0;
        check("R10 resync wins", 3'b0_00);
        give_ticks(63);  check("R10 strobe not counted", 3'b0_00);
        give_ticks(1);   check("R10 step after full count", 3'b0_01);
    endtask

    task automatic t_idle();
        repeat (500) @(negedge clk);
        check("R11 idle hold", 3'b0_01);
    endtask

    task automatic t_sw();
        sw_mode_i = 1'b1;
        for (int c = 0; c < 2; c++) begin
            for (int b = 0; b < 4; b++) begin
                sw_carrier_i = c[0];
                sw_bit_i     = b[1:0];
                @(negedge clk);
                check("R2 R3 software fields", {c[0], b[1:0]});
            end
        end
    endtask

    task automatic t_sw_ignore();
        sw_carrier_i = 1'b1;
        sw_bit_i     = 2'b10;
        @(negedge clk);
        pulse_resync();  check("R9 resync ignored in sw", 3'b1_10);
        give_ticks(100); check("R9 strobes ignored in sw", 3'b1_10);
    endtask

    task automatic t_switch();
        sw_mode_i = 1'b0;
        @(negedge clk);
        check("R8 switch to hw fastest", 3'b0_00);
        give_ticks(63);  check("R8 full count needed", 3'b0_00);
        give_ticks(1);   check("R8 first step after switch", 3'b0_01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ramp();
        t_saturate();
        t_resync();
        t_partial();
        t_coincide();
        t_idle();
        t_sw();
        t_sw_ignore();
        t_switch();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule